// File: doc/BRIEF.md
# Power Management SMI Status Aggregator

This block holds a 16-bit global power-management status word and a companion enable word. It catches wake and system-management events, combines them, and drives a system management interrupt request toward the processor. The event sources are an interrupt-resume event (any qualifying IRQ line rising), an active-low external SMI pin, a legacy keyboard/mouse event, an internal one-second tick, and the summary vectors of two lower-level status registers (a general-purpose one and a PM1 one).

Some status bits are sticky latches that software clears by writing ones. Others are read-only summaries that follow the lower-level registers. Each SMI source is gated by its own enable bit and by a global SMI enable. The block sits in the standby power domain, so its only reset is the resume-well reset. Software reaches both words through a single-cycle register port with one address bit. Reads are combinational.

Top module: `pm_evt_hub`

## Requirements
- R1: After the resume reset `rsmRstN` is released, the status word (regAddr=0) and the enable word (regAddr=1) read 0x0000, apart from status bit 8, which the tick may set. `smiReq`, `smiFlag` and `s1Wake` are 0.
- R2: A rising edge on any of `irqLines` 15..3 or line 1 sets status bit 11. Rising edges on lines 0 and 2 have no effect.
- R3: `s1Wake` is 1 one cycle after status bit 11 and enable bit 11 are both 1, and it returns to 0 one cycle after either of them clears.
- R4: Status bits 11..8 are sticky. Writing 1 to one of these bits at regAddr=0 clears it, and writing 0 leaves it unchanged. An input held high sets its bit only once per rising edge.
- R5: If a hardware set and a software clear of the same sticky bit fall in the same cycle, the bit stays 1.
- R6: Status bit 7 reads 1 exactly when `gpSummary` is nonzero, and status bit 6 reads 1 exactly when `pm1Summary` is nonzero, each with one cycle of latency. Writes do not affect either bit.
- R7: Status bit 8 is set once every TICK_PERIOD clock cycles.
- R8: `smiReq` is 1 one cycle after the following holds: at least one status bit among 10..6 is 1, its enable bit in the same position of the enable word is 1, and global enable bit 0 of the enable word is 1. Bit 11 is not an SMI source.
- R9: `smiFlag` pulses for exactly one cycle, in the first cycle of each `smiReq` assertion.
- R10: Status bits 15..12 are plain read/write storage that resets to 0. Status bits 5..0 always read 0.
- R11: A falling edge on `extSmiN` sets status bit 10. A rising edge on `legacyEvt` sets status bit 9.
- R12: Enable word bits 11..0 are read/write storage, and bits 15..12 read 0. Only bits 11..6 and bit 0 take part in the gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rsmRstN | input | 1 | Resume-well reset, active low |
| irqLines | input | IRQ_W | Raw interrupt lines |
| extSmiN | input | 1 | External SMI pin, active low |
| legacyEvt | input | 1 | Legacy keyboard/mouse event |
| gpSummary | input | GP_W | General-purpose status vector |
| pm1Summary | input | PM1_W | PM1 status vector |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = status word, 1 = enable word |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the addressed word |
| smiReq | output | 1 | SMI request level |
| smiFlag | output | 1 | One-cycle pulse at the start of each SMI request |
| s1Wake | output | 1 | Wake-from-S1 indication |

## Verification
The hardest case to reach from the ports is a hardware set that lands in the same cycle as a software write-one-to-clear of the same sticky bit. The input path has a fixed latency of two synchroniser flops plus an edge detector. The stimulus therefore first sets the legacy bit, then raises `legacyEvt` again and issues the clearing write exactly two cycles later, so the write and the set coincide. The tick period is measured between two consecutive set events with a clear in between. The SMI gate is walked through each source with the global enable both off and on, and the flag pulses are counted.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W   = 16;
  localparam int B_IRQ   = 11;
  localparam int B_EXT   = 10;
  localparam int B_LEG   = 9;
  localparam int B_SEC   = 8;
  localparam int B_GP    = 7;
  localparam int B_PM1   = 6;
  localparam int B_GSMI  = 0;

  typedef struct packed {
    logic [3:0] setSticky;  // 3 irq, 2 ext, 1 legacy, 0 second
    logic       wrStatus;
    logic       wrEnable;
  } ctrlStrb_t;
endpackage

// File: rtl/pm_evt_edge.sv
module pm_evt_edge #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] stageQ [STAGES];
  logic [W-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '0;
      prevQ <= '0;
    end else begin
      stageQ[0] <= din;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
      prevQ <= stageQ[STAGES-1];
    end
  end

  assign rise = stageQ[STAGES-1] & ~prevQ;
endmodule

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter int           IRQ_W       = 16,
  parameter logic [15:0]  IRQ_MASK    = 16'hFFFA,
  parameter int           SYNC_STAGES = 2,
  parameter int           TICK_PERIOD = 50_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IRQ_W-1:0] irqLines,
  input  logic             extSmiN,
  input  logic             legacyEvt,
  input  logic             wrEn,
  input  logic             regAddr,
  output ctrlStrb_t        strb
);
  localparam int SRC_W = IRQ_W + 2;
  localparam int CNT_W = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_PERIOD - 1);

  logic [IRQ_W-1:0] irqQual;
  logic [SRC_W-1:0] rise;
  logic [CNT_W-1:0] tickCnt;
  logic             tickNow;

  assign irqQual = irqLines & IRQ_MASK[IRQ_W-1:0];

  pm_evt_edge #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rstN (rstN),
    .din  ({irqQual, ~extSmiN, legacyEvt}),
    .rise (rise)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tickCnt <= '0;
    else if (tickNow) tickCnt <= '0;
    else              tickCnt <= tickCnt + 1'b1;
  end
  assign tickNow = (tickCnt == CNT_LAST);

  always_comb begin
    strb.setSticky[3] = |rise[SRC_W-1:2];
    strb.setSticky[2] = rise[1];
    strb.setSticky[1] = rise[0];
    strb.setSticky[0] = tickNow;
    strb.wrStatus     = wrEn & ~regAddr;
    strb.wrEnable     = wrEn & regAddr;
  end
endmodule

// File: rtl/pm_evt_dp.sv
module pm_evt_dp
  import pm_evt_pkg::*;
#(
  parameter int GP_W  = 8,
  parameter int PM1_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [REG_W-1:0] wrData,
  input  logic [GP_W-1:0]  gpSummary,
  input  logic [PM1_W-1:0] pm1Summary,
  output logic [REG_W-1:0] statusWord,
  output logic [REG_W-1:0] enableWord,
  output logic             smiReq,
  output logic             smiFlag,
  output logic             s1Wake
);
  logic [3:0]  rsvQ;
  logic [3:0]  stickyQ;
  logic [1:0]  sumQ;      // 1 gp, 0 pm1
  logic [5:0]  enSrcQ;    // enables for bits 11..6
  logic [4:0]  enRsvQ;
  logic        gSmiEnQ;
  logic [3:0]  clrMask;
  logic        smiGate;

  assign clrMask = strb.wrStatus ? wrData[B_IRQ:B_SEC] : 4'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsvQ    <= '0;
      stickyQ <= '0;
      sumQ    <= '0;
    end else begin
      stickyQ <= (stickyQ & ~clrMask) | strb.setSticky;
      sumQ    <= {|gpSummary, |pm1Summary};
      if (strb.wrStatus) rsvQ <= wrData[REG_W-1:12];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSrcQ  <= '0;
      enRsvQ  <= '0;
      gSmiEnQ <= 1'b0;
    end else if (strb.wrEnable) begin
      enSrcQ  <= wrData[B_IRQ:B_PM1];
      enRsvQ  <= wrData[5:1];
      gSmiEnQ <= wrData[B_GSMI];
    end
  end

  assign statusWord = {rsvQ, stickyQ, sumQ, 6'b0};
  assign enableWord = {4'b0, enSrcQ, enRsvQ, gSmiEnQ};

  assign smiGate = gSmiEnQ & (|({stickyQ[2:0], sumQ} & enSrcQ[4:0]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smiReq  <= 1'b0;
      smiFlag <= 1'b0;
      s1Wake  <= 1'b0;
    end else begin
      smiReq  <= smiGate;
      smiFlag <= smiGate & ~smiReq;
      s1Wake  <= stickyQ[3] & enSrcQ[5];
    end
  end
endmodule

// File: rtl/pm_evt_hub.sv
module pm_evt_hub
  import pm_evt_pkg::*;
#(
  parameter int          IRQ_W       = 16,
  parameter logic [15:0] IRQ_MASK    = 16'hFFFA,
  parameter int          GP_W        = 8,
  parameter int          PM1_W       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          TICK_PERIOD = 50_000_000
) (
  input  logic             clk,
  input  logic             rsmRstN,
  input  logic [IRQ_W-1:0] irqLines,
  input  logic             extSmiN,
  input  logic             legacyEvt,
  input  logic [GP_W-1:0]  gpSummary,
  input  logic [PM1_W-1:0] pm1Summary,
  input  logic             wrEn,
  input  logic             regAddr,
  input  logic [15:0]      wrData,
  output logic [15:0]      rdData,
  output logic             smiReq,
  output logic             smiFlag,
  output logic             s1Wake
);
  ctrlStrb_t        strb;
  logic [REG_W-1:0] statusWord;
  logic [REG_W-1:0] enableWord;

  pm_evt_ctrl #(
    .IRQ_W(IRQ_W), .IRQ_MASK(IRQ_MASK),
    .SYNC_STAGES(SYNC_STAGES), .TICK_PERIOD(TICK_PERIOD)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rsmRstN),
    .irqLines  (irqLines),
    .extSmiN   (extSmiN),
    .legacyEvt (legacyEvt),
    .wrEn      (wrEn),
    .regAddr   (regAddr),
    .strb      (strb)
  );

  pm_evt_dp #(.GP_W(GP_W), .PM1_W(PM1_W)) u_dp (
    .clk        (clk),
    .rstN       (rsmRstN),
    .strb       (strb),
    .wrData     (wrData),
    .gpSummary  (gpSummary),
    .pm1Summary (pm1Summary),
    .statusWord (statusWord),
    .enableWord (enableWord),
    .smiReq     (smiReq),
    .smiFlag    (smiFlag),
    .s1Wake     (s1Wake)
  );

  assign rdData = regAddr ? enableWord : statusWord;
endmodule

// File: rtl/pm_evt_hub_chk.sv
module pm_evt_hub_chk #(
  parameter int GP_W  = 8,
  parameter int PM1_W = 16
) (
  input logic             clk,
  input logic             rsmRstN,
  input logic [3:0]       setSticky,
  input logic             wrStatus,
  input logic [3:0]       wrClr,
  input logic [GP_W-1:0]  gpSummary,
  input logic [PM1_W-1:0] pm1Summary,
  input logic [11:6]      statusBits,
  input logic [11:6]      enBits,
  input logic             gEn,
  input logic             smiReq,
  input logic             smiFlag,
  input logic             s1Wake
);
  for (genvar i = 0; i < 4; i++) begin : g_sticky
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rsmRstN)
      (wrStatus && wrClr[i] && !setSticky[i]) |=> !statusBits[8+i]);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rsmRstN)
      (statusBits[8+i] && !(wrStatus && wrClr[i])) |=> statusBits[8+i]);
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rsmRstN)
      setSticky[i] |=> statusBits[8+i]);
  end

  assert_gp_sum_R6: assert property (@(posedge clk) disable iff (!rsmRstN)
    $past(rsmRstN) |-> (statusBits[7] == $past(|gpSummary)));
  assert_pm1_sum_R6: assert property (@(posedge clk) disable iff (!rsmRstN)
    $past(rsmRstN) |-> (statusBits[6] == $past(|pm1Summary)));

  assert_smi_on_R8: assert property (@(posedge clk) disable iff (!rsmRstN)
    ((|(statusBits[10:6] & enBits[10:6])) && gEn) |=> smiReq);
  assert_smi_off_R8: assert property (@(posedge clk) disable iff (!rsmRstN)
    !((|(statusBits[10:6] & enBits[10:6])) && gEn) |=> !smiReq);

  assert_flag_start_R9: assert property (@(posedge clk) disable iff (!rsmRstN)
    $rose(smiReq) |-> smiFlag);
  assert_flag_single_R9: assert property (@(posedge clk) disable iff (!rsmRstN)
    smiFlag |-> (smiReq && !$past(smiReq)));

  assert_wake_on_R3: assert property (@(posedge clk) disable iff (!rsmRstN)
    (statusBits[11] && enBits[11]) |=> s1Wake);
  assert_wake_off_R3: assert property (@(posedge clk) disable iff (!rsmRstN)
    !(statusBits[11] && enBits[11]) |=> !s1Wake);
endmodule

bind pm_evt_hub pm_evt_hub_chk #(.GP_W(GP_W), .PM1_W(PM1_W)) u_chk (
  .clk        (clk),
  .rsmRstN    (rsmRstN),
  .setSticky  (strb.setSticky),
  .wrStatus   (strb.wrStatus),
  .wrClr      (wrData[11:8]),
  .gpSummary  (gpSummary),
  .pm1Summary (pm1Summary),
  .statusBits (statusWord[11:6]),
  .enBits     (enableWord[11:6]),
  .gEn        (enableWord[0]),
  .smiReq     (smiReq),
  .smiFlag    (smiFlag),
  .s1Wake     (s1Wake)
);

// File: tb/test_pm_evt_hub.sv
module test_pm_evt_hub;
  localparam int TICK = 20;
  localparam logic [15:0] NO_TICK = 16'hFEFF;

  logic        clk = 1'b0;
  logic        rsmRstN = 1'b0;
  logic [15:0] irqLines = '0;
  logic        extSmiN = 1'b1;
  logic        legacyEvt = 1'b0;
  logic [7:0]  gpSummary = '0;
  logic [15:0] pm1Summary = '0;
  logic        wrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        smiReq, smiFlag, s1Wake;

  always #10 clk = ~clk;  // 50 MHz

  pm_evt_hub #(.TICK_PERIOD(TICK)) i_pm_evt_hub (
    .clk(clk), .rsmRstN(rsmRstN), .irqLines(irqLines), .extSmiN(extSmiN),
    .legacyEvt(legacyEvt), .gpSummary(gpSummary), .pm1Summary(pm1Summary),
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .smiReq(smiReq), .smiFlag(smiFlag), .s1Wake(s1Wake)
  );

  typedef struct {
    string       tag;
    int          kind;   // 0 rdData, 1 smiReq, 2 s1Wake, 3 value
    logic [15:0] mask;
    logic [15:0] exp;
    int          act;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int flagCnt = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc++;
  always @(negedge clk) if (smiFlag) flagCnt++;

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdData & it.mask;
        1: act = {15'b0, smiReq};
        2: act = {15'b0, s1Wake};
        default: act = it.act[15:0];
      endcase
      checks++;
      if (act !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp & it.mask);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic regWrite(input logic addr, input logic [15:0] d);
    step(); regAddr = addr; wrData = d; wrEn = 1'b1;
    step(); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic expReg(input string tag, input logic addr,
                        input logic [15:0] mask, input logic [15:0] e);
    item_t it;
    step(); regAddr = addr;
    it.tag = tag; it.kind = 0; it.mask = mask; it.exp = e; it.act = 0;
    q.push_back(it);
  endtask

  task automatic expPin(input string tag, input int kind, input logic e);
    item_t it;
    step();
    it.tag = tag; it.kind = kind; it.mask = 16'h0001; it.exp = {15'b0, e}; it.act = 0;
    q.push_back(it);
  endtask

  task automatic expVal(input string tag, input int a, input int e);
    item_t it;
    it.tag = tag; it.kind = 3; it.mask = 16'hFFFF; it.exp = e[15:0]; it.act = a;
    q.push_back(it);
    step();
  endtask

  task automatic irqPulse(input int line);
    step(); irqLines[line] = 1'b1;
    step(3); irqLines = '0;
    step(4);
  endtask

  task automatic summary();
    step(2);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int f0, t0, t1;
    step(3);
    rsmRstN = 1'b1;
    // R1 reset state
    expReg("R1 status after reset", 1'b0, NO_TICK, 16'h0000);
    expReg("R1 enable after reset", 1'b1, 16'hFFFF, 16'h0000);
    expPin("R1 smiReq after reset", 1, 1'b0);
    expPin("R1 s1Wake after reset", 2, 1'b0);

    // R10 reserved and low bits, R6 writes ignored on 7:6
    regWrite(1'b0, 16'hF0FF);
    expReg("R10 reserved readback / low zero / R6 ro", 1'b0, NO_TICK, 16'hF000);
    regWrite(1'b0, 16'h0000);
    expReg("R10 reserved cleared", 1'b0, NO_TICK, 16'h0000);

    // R12 enable word
    regWrite(1'b1, 16'hFFFF);
    expReg("R12 enable readback", 1'b1, 16'hFFFF, 16'h0FFF);
    regWrite(1'b1, 16'h0000);
    expReg("R12 enable cleared", 1'b1, 16'hFFFF, 16'h0000);

    // R2 irq qualification
    irqPulse(0);
    expReg("R2 irq0 ignored", 1'b0, 16'h0800, 16'h0000);
    irqPulse(2);
    expReg("R2 irq2 ignored", 1'b0, 16'h0800, 16'h0000);
    irqPulse(5);
    expReg("R2 irq5 sets", 1'b0, 16'h0800, 16'h0800);
    regWrite(1'b0, 16'h0800);
    expReg("R4 w1c clears bit11", 1'b0, 16'h0800, 16'h0000);
    irqPulse(1);
    expReg("R2 irq1 sets", 1'b0, 16'h0800, 16'h0800);
    regWrite(1'b0, 16'h0800);
    irqPulse(15);
    expReg("R2 irq15 sets", 1'b0, 16'h0800, 16'h0800);

    // R3 wake and R8 bit11 not an SMI source
    regWrite(1'b1, 16'h0801);
    step(2);
    expPin("R3 wake asserted", 2, 1'b1);
    expPin("R8 bit11 no smi", 1, 1'b0);
    regWrite(1'b0, 16'h0800);
    step(2);
    expPin("R3 wake drops", 2, 1'b0);
    regWrite(1'b1, 16'h0000);

    // R11 ext and legacy, R4 write-zero and held input
    step(); extSmiN = 1'b0; step(6);
    expReg("R11 ext falling sets bit10", 1'b0, 16'h0400, 16'h0400);
    regWrite(1'b0, 16'h0000);
    expReg("R4 write zero keeps bit10", 1'b0, 16'h0400, 16'h0400);
    regWrite(1'b0, 16'h0400);
    step(4);
    expReg("R4 held-low ext sets once", 1'b0, 16'h0400, 16'h0000);
    extSmiN = 1'b1; step(4);
    step(); legacyEvt = 1'b1; step(6);
    expReg("R11 legacy rising sets bit9", 1'b0, 16'h0200, 16'h0200);
    regWrite(1'b0, 16'h0200);
    step(4);
    expReg("R4 held legacy sets once", 1'b0, 16'h0200, 16'h0000);
    legacyEvt = 1'b0; step(4);

    // R5 set wins over coincident clear
    step(); legacyEvt = 1'b1; step(6); legacyEvt = 1'b0; step(4);
    expReg("R5 precondition bit9 set", 1'b0, 16'h0200, 16'h0200);
    step(); legacyEvt = 1'b1;
    step();
    step(); regAddr = 1'b0; wrData = 16'h0200; wrEn = 1'b1;
    step(); wrEn = 1'b0; wrData = '0;
    expReg("R5 set wins over clear", 1'b0, 16'h0200, 16'h0200);
    legacyEvt = 1'b0; step(4);
    regWrite(1'b0, 16'h0200);
    expReg("R5 ordinary clear afterwards", 1'b0, 16'h0200, 16'h0000);

    // R8 gating and R9 flag
    step(4); f0 = flagCnt;
    regWrite(1'b1, 16'h0400);
    step(); extSmiN = 1'b0; step(3); extSmiN = 1'b1; step(4);
    expPin("R8 no global enable no smi", 1, 1'b0);
    regWrite(1'b1, 16'h0401);
    step(2);
    expPin("R8 ext with enables raises smi", 1, 1'b1);
    regWrite(1'b0, 16'h0400);
    step(2);
    expPin("R8 smi drops after clear", 1, 1'b0);
    regWrite(1'b1, 16'h0081);
    gpSummary = 8'h20; step(3);
    expPin("R8 gp source raises smi", 1, 1'b1);
    expReg("R6 bit7 follows gp", 1'b0, 16'h00C0, 16'h0080);
    regWrite(1'b0, 16'h0080);
    expReg("R6 write does not clear bit7", 1'b0, 16'h00C0, 16'h0080);
    gpSummary = 8'h00; step(3);
    expPin("R8 smi drops with gp", 1, 1'b0);
    regWrite(1'b1, 16'h0041);
    pm1Summary = 16'h8000; step(3);
    expReg("R6 bit6 follows pm1", 1'b0, 16'h00C0, 16'h0040);
    expPin("R8 pm1 source raises smi", 1, 1'b1);
    pm1Summary = 16'h0000; step(3);
    expReg("R6 bit6 clears", 1'b0, 16'h00C0, 16'h0000);
    regWrite(1'b1, 16'h0000);
    step(2);
    expVal("R9 one flag per smi assertion", flagCnt - f0, 3);

    // R7 tick period
    regWrite(1'b0, 16'h0100);
    regAddr = 1'b0;
    do step(); while (!rdData[8]);
    regWrite(1'b0, 16'h0100);
    regAddr = 1'b0;
    do step(); while (!rdData[8]);
    t0 = cyc;
    regWrite(1'b0, 16'h0100);
    regAddr = 1'b0;
    do step(); while (!rdData[8]);
    t1 = cyc;
    expVal("R7 tick interval", t1 - t0, TICK);

    done = 1;
    summary();
  end
endmodule